// File: doc/BRIEF.md
# Jitter-Folding Random Bit Sampler

This block is the digital core of a random bit source built from two clocks whose frequencies are locked in a fixed rational ratio KM:KD. It runs entirely in the sampling clock domain. The second, jittered clock arrives as an asynchronous data input. A flip-flop chain synchronizes it, and every synchronized sample is folded by XOR into an accumulator. When KD samples have been folded, which covers one full repetition of the beat pattern between the two clocks, the accumulated parity becomes one raw random bit and the accumulator starts again from zero.

Raw bits are shifted into a word register with the first bit landing in bit 0. Each complete word is presented with a one-cycle strobe. The raw bit and its own one-cycle strobe are also brought out, so that an online health monitor can watch the unpacked stream. With the default ratio of 127:120 and a 240 MHz sampling clock, one raw bit appears every 120 cycles, which gives 2 Mbit/s. Setting KM=116 and KD=105 selects the alternative ratio with no change to the code.

Top module: `jitter_fold_trng`

## Requirements
- R1: The jittered input passes through a synchronizer of SYNC_STAGES flip-flops, at least 2 and 2 by default. A level driven before clock edge k enters the fold at edge k+SYNC_STAGES.
- R2: After reset is released, `raw_vld_o` is high for exactly one cycle in every KD cycles. It first goes high after the KD-th clock edge and is low in all other cycles.
- R3: `raw_bit_o` equals the XOR of the KD consecutive synchronized samples of the period that has just closed, including the sample taken on the closing edge.
- R4: The accumulator starts every period at zero, so no sample contributes to more than one raw bit.
- R5: Raw bits fill `word_o` starting at the least significant bit. Bit i of a word is the i-th raw bit of that group, with i=0 being the oldest.
- R6: `word_vld_o` goes high for exactly one cycle, in the cycle after every WORD_W-th raw strobe. `word_o` changes only in the cycle where `word_vld_o` is high.
- R7: A synchronous active-high reset clears the synchronizer, the period counter, the accumulator, the shift register, the word and both strobes. The period count restarts from zero after reset, even if reset arrives in the middle of a period.
- R8: Parameters alone select the 127:120 default and the 116:105 alternative. The raw strobe period then follows KD, which is 120 or 105 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_i | input | 1 | Synchronous active-high reset |
| jit_clk_i | input | 1 | Jittered clock, sampled as asynchronous data |
| raw_bit_o | output | 1 | Folded raw bit of the last period |
| raw_vld_o | output | 1 | One-cycle strobe marking a new raw bit |
| word_o | output | WORD_W | Packed raw bits, oldest in bit 0 |
| word_vld_o | output | 1 | One-cycle strobe marking a new word |

## Verification
The bench drives a single-cycle pulse timed to arrive as the last sample of the first period. If the synchronizer depth were wrong, or if the closing sample were dropped from the fold, that pulse would land in the wrong raw bit or disappear from the stream. Constant-one input with an odd KD exposes an accumulator that is not cleared, because the parity would then alternate instead of repeating. A bit-ordering error in the packer shows up as reversed words under pseudo-random input. Reset is applied again in the middle of a period for the 120- and 105-cycle instances. A counter that survived that reset would strobe early.

// File: rtl/jft_pkg.sv
package jft_pkg;

    // width of a counter that must hold values 0 .. n-1
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/jft_sync.sv
module jft_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign sync_o = st_q.chain[STAGES-1];
endmodule

// File: rtl/jft_fold.sv
module jft_fold
    import jft_pkg::*;
#(
    parameter int unsigned KD = 120
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic samp_i,
    output logic raw_bit_o,
    output logic raw_vld_o
);
    localparam int unsigned CNT_W = cnt_width(KD);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(KD - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             acc;
        logic             raw;
        logic             vld;
    } fold_state_t;

    fold_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (st_q.cnt == CNT_LAST) begin
            // period closes: the current sample is part of it
            st_d.cnt = '0;
            st_d.raw = st_q.acc ^ samp_i;
            st_d.vld = 1'b1;
            st_d.acc = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
            st_d.acc = st_q.acc ^ samp_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign raw_bit_o = st_q.raw;
    assign raw_vld_o = st_q.vld;
endmodule

// File: rtl/jft_pack.sv
module jft_pack
    import jft_pkg::*;
#(
    parameter int unsigned WORD_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              bit_i,
    input  logic              bit_vld_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_vld_o
);
    localparam int unsigned BC_W = cnt_width(WORD_W);
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [BC_W-1:0]   bcnt;
        logic [WORD_W-1:0] word;
        logic              vld;
    } pack_state_t;

    pack_state_t st_d, st_q;
    logic [WORD_W-1:0] shifted;

    always_comb begin
        // new bit enters at the top; the oldest ends up in bit 0
        shifted  = {bit_i, st_q.shreg[WORD_W-1:1]};
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (bit_vld_i) begin
            st_d.shreg = shifted;
            if (st_q.bcnt == BC_LAST) begin
                st_d.bcnt = '0;
                st_d.word = shifted;
                st_d.vld  = 1'b1;
            end else begin
                st_d.bcnt = st_q.bcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign word_o     = st_q.word;
    assign word_vld_o = st_q.vld;
endmodule

// File: rtl/jitter_fold_trng.sv
module jitter_fold_trng #(
    parameter int unsigned KM          = 127,
    parameter int unsigned KD          = 120,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned WORD_W      = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              jit_clk_i,
    output logic              raw_bit_o,
    output logic              raw_vld_o,
    output logic [WORD_W-1:0] word_o,
    output logic              word_vld_o
);
    generate
        if (SYNC_STAGES < 2 || KD < 2 || KM < 1 || KM == KD || WORD_W < 2) begin : g_bad_cfg
            $error("jitter_fold_trng: unsupported parameter set");
        end
    endgenerate

    logic samp;

    jft_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (jit_clk_i),
        .sync_o  (samp)
    );

    jft_fold #(.KD(KD)) u_fold (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .samp_i    (samp),
        .raw_bit_o (raw_bit_o),
        .raw_vld_o (raw_vld_o)
    );

    jft_pack #(.WORD_W(WORD_W)) u_pack (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .bit_i      (raw_bit_o),
        .bit_vld_i  (raw_vld_o),
        .word_o     (word_o),
        .word_vld_o (word_vld_o)
    );
endmodule

// File: rtl/jft_checker.sv
module jft_checker #(
    parameter int unsigned KD     = 120,
    parameter int unsigned WORD_W = 8
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              raw_vld_o,
    input logic [WORD_W-1:0] word_o,
    input logic              word_vld_o
);
    localparam int unsigned GAP_W = $clog2(KD + 2);

    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)          gap_q <= '0;
        else if (raw_vld_o) gap_q <= GAP_W'(1);
        else if (gap_q <= GAP_W'(KD)) gap_q <= gap_q + 1'b1;
    end

    assert_raw_period_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        raw_vld_o |-> (gap_q == GAP_W'(KD)));

    assert_raw_not_late_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        gap_q <= GAP_W'(KD));

    assert_raw_single_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        raw_vld_o |=> !raw_vld_o);

    assert_word_single_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        word_vld_o |=> !word_vld_o);

    assert_word_follows_raw_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        word_vld_o |-> $past(raw_vld_o));

    assert_word_stable_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        !word_vld_o |-> $stable(word_o));

    assert_reset_clears_R7: assert property (@(posedge clk_i)
        rst_i |=> (!raw_vld_o && !word_vld_o && word_o == '0));
endmodule

bind jitter_fold_trng jft_checker #(.KD(KD), .WORD_W(WORD_W)) u_jft_checker (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .raw_vld_o  (raw_vld_o),
    .word_o     (word_o),
    .word_vld_o (word_vld_o)
);

// File: tb/jitter_fold_trng_bench.sv
module jitter_fold_trng_bench;
    localparam int CLK_PERIOD = 10;
    localparam int KD_S = 7;
    localparam int NS_S = 3;
    localparam int WW   = 8;
    localparam int KD_A = 120;
    localparam int KD_B = 105;
    localparam int NS_D = 2;
    localparam int HMAX = 2048;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic jit = 1'b0;

    logic          raw_s, rv_s, wv_s;
    logic [WW-1:0] word_s;
    logic          raw_a, rv_a, wv_a;
    logic [7:0]    word_a;
    logic          raw_b, rv_b, wv_b;
    logic [7:0]    word_b;

    int total = 0;
    int bad   = 0;
    bit hist   [HMAX];
    bit rawexp [HMAX];
    logic [WW-1:0] lastword;
    logic [15:0]   lfsr;

    always #(CLK_PERIOD/2) clk = ~clk;

    jitter_fold_trng #(.KM(8), .KD(KD_S), .SYNC_STAGES(NS_S), .WORD_W(WW)) u_jitter_fold_trng (
        .clk_i(clk), .rst_i(rst), .jit_clk_i(jit),
        .raw_bit_o(raw_s), .raw_vld_o(rv_s), .word_o(word_s), .word_vld_o(wv_s));

    jitter_fold_trng u_dflt (
        .clk_i(clk), .rst_i(rst), .jit_clk_i(jit),
        .raw_bit_o(raw_a), .raw_vld_o(rv_a), .word_o(word_a), .word_vld_o(wv_a));

    jitter_fold_trng #(.KM(116), .KD(KD_B)) u_alt (
        .clk_i(clk), .rst_i(rst), .jit_clk_i(jit),
        .raw_bit_o(raw_b), .raw_vld_o(rv_b), .word_o(word_b), .word_vld_o(wv_b));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // sample folded at edge m is the level driven ns edges earlier (0 before that)
    function automatic bit exp_raw(input int kd, input int ns, input int k);
        bit r = 1'b0;
        for (int m = k - kd + 1; m <= k; m++)
            if (m >= ns) r ^= hist[m - ns];
        return r;
    endfunction

    function automatic bit patval(input int p, input int c);
        case (p)
            0: return 1'b0;
            1: return 1'b1;
            2: return c[0];
            3: return (c == KD_S - 1 - NS_S);
            4: return ((c * 2 * 8) / KD_S) % 2 == 1;
            default: return lfsr[0];
        endcase
    endfunction

    // check the outputs produced by clock edge k
    task automatic check_edge(input int k);
        bit es;
        es = (k % KD_S) == KD_S - 1;
        check(rv_s == es, "R2 raw strobe timing", rv_s, es);
        if (es) begin
            rawexp[k / KD_S] = exp_raw(KD_S, NS_S, k);
            check(raw_s == rawexp[k / KD_S], "R1 R3 R4 raw bit value", raw_s, rawexp[k / KD_S]);
        end
        es = (k > 0) && (k % (KD_S * WW) == 0);
        check(wv_s == es, "R6 word strobe timing", wv_s, es);
        if (es) begin
            int w = k / (KD_S * WW) - 1;
            for (int i = 0; i < WW; i++) lastword[i] = rawexp[w * WW + i];
        end
        check(word_s == lastword, "R5 R6 word value", word_s, lastword);
        es = (k % KD_A) == KD_A - 1;
        check(rv_a == es, "R8 R7 strobe period 120", rv_a, es);
        if (es) check(raw_a == exp_raw(KD_A, NS_D, k), "R8 R3 raw bit 120", raw_a, exp_raw(KD_A, NS_D, k));
        es = (k % KD_B) == KD_B - 1;
        check(rv_b == es, "R8 R7 strobe period 105", rv_b, es);
        if (es) check(raw_b == exp_raw(KD_B, NS_D, k), "R8 R3 raw bit 105", raw_b, exp_raw(KD_B, NS_D, k));
    endtask

    initial begin
        lfsr = 16'hACE1;
        for (int p = 0; p < 6; p++) begin
            int len = (p == 5) ? 2000 : 168;
            rst = 1'b1;
            jit = 1'b1;
            repeat (3) @(negedge clk);
            check(rv_s == 0 && wv_s == 0 && word_s == 0, "R7 reset clears small", word_s, 0);
            check(rv_a == 0 && rv_b == 0 && word_a == 0 && word_b == 0, "R7 reset clears defaults", rv_a, 0);
            lastword = '0;
            rst = 1'b0;
            hist[0] = patval(p, 0);
            jit = hist[0];
            for (int c = 0; c < len; c++) begin
                @(negedge clk);
                check_edge(c);
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                hist[c + 1] = patval(p, c + 1);
                jit = hist[c + 1];
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule